// File: doc/BRIEF.md
# Phase-Lock Timeout Alarm Timer

This block measures how long a clock-recovery loop has been trying to lock. While the loop reports one of its three unlocked acquisition modes, the block counts one-second ticks. When the count reaches a programmable limit, the block raises a sticky lock alarm for the input the loop is currently following.

The limit comes from one 8-bit configuration byte. The low six bits are an unsigned count. The top two bits pick a power-of-two step of 2, 4, 8 or 16 seconds. A count of zero turns the alarm off. Software writes the byte through a simple write strobe, and clears the alarm with a separate strobe. The loop state machine and the tick source are outside this block.

Top module: `lock_timeout_alarm`

## Requirements
- R1: After reset `lock_alarm` is 0 and the configuration byte is 0x3C (count 60, step code 0), so the timeout is 120 ticks.
- R2: The timeout in ticks is count × 2^(step+1), where count is `cfg_wdata[5:0]` and step is `cfg_wdata[7:6]`. Step codes 0, 1, 2 and 3 give 2, 4, 8 and 16 ticks per count unit. The alarm is set on the clock edge that takes the tick whose number equals the timeout, and it reads 1 from the next cycle.
- R3: Ticks advance the timer only while `loop_mode` is 1 (prelocked), 2 (prelocked 2) or 3 (phase-lost). In mode 0 (locked) and in modes 4 to 7 (other), ticks never raise the alarm.
- R4: Any cycle in a mode outside 1 to 3 clears the elapsed count and ends the timed episode.
- R5: Once set, `lock_alarm` stays 1, even after the loop leaves the timed modes, until `alarm_clr` is pulsed.
- R6: The alarm fires at most once per timed episode. After it is cleared, further ticks in the same episode do not set it again.
- R7: A count field of zero disables the alarm for every step code.
- R8: A write (`cfg_we`=1) loads the byte and restarts the elapsed count from zero. A tick in the same cycle as the write is not counted.
- R9: If the expiring tick and `alarm_clr` fall in the same cycle, the alarm is set.
- R10: Moving between modes 1, 2 and 3 keeps the elapsed count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| loop_mode | input | 3 | Loop mode: 0 locked, 1 prelocked, 2 prelocked 2, 3 phase-lost, 4 to 7 other |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte: [7:6] step code, [5:0] count |
| alarm_clr | input | 1 | Clears the lock alarm |
| lock_alarm | output | 1 | Sticky phase-lock alarm |

## Verification
Each step code is tested one tick short of its limit and then at the limit. A design with an off-by-one error, or one that wraps the shift amount at step code 3, would raise the alarm early, late or never.

The bench interrupts a partial count with a locked cycle and also restarts it with a write. A design that kept stale elapsed time across either event would fire early.

It also clears the alarm inside a still-running episode. A timer that restarted after firing would raise the alarm a second time.

A clear strobe that coincides with the expiring tick, and a zero count under a nonzero step code, are driven as well. These catch a lost alarm and a zero count that is treated as a short timeout.

// File: rtl/lock_timeout_alarm.sv
module lock_timeout_alarm #(
  parameter int CNT_W = 6,
  parameter int MUL_W = 2,
  parameter logic [CNT_W+MUL_W-1:0] CFG_RESET = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] loop_mode,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       alarm_clr,
  output logic       lock_alarm
);
  localparam int CFG_W = CNT_W + MUL_W;
  localparam int EL_W  = CNT_W + (1 << MUL_W);

  logic [CFG_W-1:0] cfg_r;
  logic [EL_W-1:0]  elapsed, elapsed_nx, limit;
  logic [MUL_W:0]   shamt;
  logic             fired, timed, cnt_zero, hit;

  assign timed      = (loop_mode == 3'd1) || (loop_mode == 3'd2) || (loop_mode == 3'd3);
  assign cnt_zero   = (cfg_r[CNT_W-1:0] == '0);
  assign shamt      = {1'b0, cfg_r[CFG_W-1:CNT_W]} + 1'b1;
  assign limit      = {{(EL_W-CNT_W){1'b0}}, cfg_r[CNT_W-1:0]} << shamt;
  assign elapsed_nx = elapsed + 1'b1;
  assign hit        = timed && sec_tick && !cfg_we && !fired && !cnt_zero &&
                      (elapsed_nx == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_r      <= CFG_RESET;
      elapsed    <= '0;
      fired      <= 1'b0;
      lock_alarm <= 1'b0;
    end else begin
      if (cfg_we) cfg_r <= cfg_wdata[CFG_W-1:0];

      if (cfg_we || !timed) begin
        elapsed <= '0;
        fired   <= 1'b0;
      end else begin
        if (sec_tick && !fired && !cnt_zero) elapsed <= elapsed_nx;
        if (hit) fired <= 1'b1;
      end

      if (hit)            lock_alarm <= 1'b1;
      else if (alarm_clr) lock_alarm <= 1'b0;
    end
  end
endmodule

module lock_timeout_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic [2:0] loop_mode,
  input logic       cfg_we,
  input logic       alarm_clr,
  input logic       cnt_zero,
  input logic       lock_alarm
);
  logic in_timed;
  assign in_timed = (loop_mode >= 3'd1) && (loop_mode <= 3'd3);

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_alarm && !alarm_clr) |=> lock_alarm); // R5
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr && !sec_tick) |=> !lock_alarm); // R5
  AST_UNTIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_alarm && !in_timed) |=> !lock_alarm); // R3
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_alarm && !sec_tick) |=> !lock_alarm); // R2
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_alarm && cnt_zero) |=> !lock_alarm); // R7
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_alarm && cfg_we) |=> !lock_alarm); // R8
endmodule

bind lock_timeout_alarm lock_timeout_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .loop_mode(loop_mode),
  .cfg_we(cfg_we), .alarm_clr(alarm_clr), .cnt_zero(cnt_zero),
  .lock_alarm(lock_alarm)
);

// File: tb/lock_timeout_alarm_test.sv
`timescale 1ns/1ps
module lock_timeout_alarm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [2:0] loop_mode = 3'd0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       alarm_clr = 1'b0;
  logic       lock_alarm;
  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lock_timeout_alarm uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .loop_mode(loop_mode),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .alarm_clr(alarm_clr),
    .lock_alarm(lock_alarm)
  );

  task automatic check(input string req, input logic exp);
    nvec++;
    if (lock_alarm !== exp) begin
      nerr++;
      $display("FAIL %s: lock_alarm=%b expected %b", req, lock_alarm, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(negedge clk);
    end
    sec_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    alarm_clr = 1'b1; @(negedge clk); alarm_clr = 1'b0;
  endtask

  task automatic setup(input logic [7:0] v);
    loop_mode = 3'd0; @(negedge clk);
    clr();
    cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0);
    loop_mode = 3'd1;
    ticks(119); check("R1 119 of 120", 1'b0);
    ticks(1);   check("R1 at 120", 1'b1);
  endtask

  task automatic t_scale();
    for (int m = 0; m < 4; m++) begin
      int lim = 3 * (2 << m);
      setup({m[1:0], 6'd3});
      loop_mode = 3'd1;
      ticks(lim - 1); check("R2 one short", 1'b0);
      ticks(1);       check("R2 at limit", 1'b1);
    end
  endtask

  task automatic t_untimed();
    setup(8'h02);
    loop_mode = 3'd0; ticks(10); check("R3 locked", 1'b0);
    loop_mode = 3'd5; ticks(10); check("R3 other", 1'b0);
    loop_mode = 3'd1; ticks(3);
    loop_mode = 3'd0; idle(1);
    loop_mode = 3'd1; ticks(3); check("R4 cleared by exit", 1'b0);
    ticks(1); check("R4 fresh count", 1'b1);
  endtask

  task automatic t_chain();
    setup(8'h02);
    loop_mode = 3'd1; ticks(1);
    loop_mode = 3'd2; ticks(1);
    loop_mode = 3'd3; ticks(1); check("R10 short", 1'b0);
    ticks(1); check("R10 across modes", 1'b1);
  endtask

  task automatic t_sticky_once();
    idle(5); check("R5 holds", 1'b1);
    loop_mode = 3'd0; idle(3); check("R5 after exit", 1'b1);
    clr(); check("R5 cleared", 1'b0);
    setup(8'h02);
    loop_mode = 3'd3; ticks(4); check("R6 first fire", 1'b1);
    clr(); ticks(20); check("R6 no refire", 1'b0);
  endtask

  task automatic t_zero();
    setup(8'h00); loop_mode = 3'd1; ticks(200); check("R7 zero step0", 1'b0);
    setup(8'hC0); loop_mode = 3'd2; ticks(200); check("R7 zero step3", 1'b0);
  endtask

  task automatic t_write();
    setup(8'h02);
    loop_mode = 3'd1; ticks(3);
    cfg_we = 1'b1; cfg_wdata = 8'h02; sec_tick = 1'b1; @(negedge clk);
    cfg_we = 1'b0; sec_tick = 1'b0;
    ticks(3); check("R8 restarted", 1'b0);
    ticks(1); check("R8 fires after restart", 1'b1);
  endtask

  task automatic t_prio();
    setup(8'h02);
    loop_mode = 3'd1; ticks(3);
    alarm_clr = 1'b1; sec_tick = 1'b1; @(negedge clk);
    alarm_clr = 1'b0; sec_tick = 1'b0;
    check("R9 set beats clear", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scale();
    t_untimed();
    t_chain();
    t_sticky_once();
    t_zero();
    t_write();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++; nerr++;
      $display("FAIL watchdog: run expected to finish, still running");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule